// File: doc/BRIEF.md
# Impulse H-Bridge Gate Sequencer

This block drives the four switch enables of a balanced H-bridge that radiates one rectangular impulse per data symbol. Each accepted bit starts a fixed-length symbol window of `SYM_LEN` clock cycles. The bit sets the pulse polarity (antipodal two-level signalling). The bridge first turns on one diagonal pair of switches, which makes a step in the differential load voltage. A cancelling step follows when the second low-side switch joins, so that both load terminals sit at ground. The window ends with every switch open.

A pulse-width value, counted in clock cycles, is sampled when the bit is accepted. That value sets how long the high-side switch conducts. A single dead cycle always separates the release of a high-side switch from the turn-on of the low-side switch on the same leg. A bit offered while a symbol is in flight is dropped, and a sticky flag records the drop. The predriver, the output filter and the antenna lie outside this block.

Top module: `impulse_hbridge_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, all four enables, `busy` and `overrun` are low. Reset during a symbol abandons that symbol.
- R2: When `bit_valid` is high at a clock edge with `busy` low, a symbol is accepted. `busy` is then high for exactly `SYM_LEN` cycles starting with the next cycle, and low after them.
- R3: For `bit_data`=1, the first `W` cycles of the symbol enable only `hi_right_en` and `lo_left_en`, where `W` is the effective width.
- R4: For `bit_data`=1, cycle `W` enables only `lo_left_en` (dead cycle). Cycles `W+1` up to `SYM_LEN-2` enable `lo_left_en` and `lo_right_en`. The second turn-on therefore comes `W+1` cycles after the first.
- R5: For `bit_data`=0, the sequence mirrors R3 and R4. The first `W` cycles enable `hi_left_en` and `lo_right_en`. Cycle `W` enables only `lo_right_en`. The remaining cycles up to `SYM_LEN-2` enable both low-side switches.
- R6: The last cycle of every symbol (cycle `SYM_LEN-1`), and every idle cycle, has all four enables low.
- R7: The high-side and low-side enables of one leg are never high in the same cycle. A low-side enable never rises in the cycle right after its leg's high-side enable was high.
- R8: `pulse_width` is sampled only at acceptance. Changing it during a symbol does not alter that symbol.
- R9: The effective width `W` is 1 when `pulse_width` is 0. It is `SYM_LEN-3` when `pulse_width` exceeds `SYM_LEN-3`. Otherwise it equals `pulse_width`.
- R10: A `bit_valid` while `busy` is high is ignored, so the symbol in flight keeps its polarity and timing. It sets `overrun`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Offers `bit_data` for transmission |
| bit_data | input | 1 | Symbol polarity: 1 positive, 0 negative |
| pulse_width | input | CNT_W | Requested high-side conduction time in cycles |
| hi_left_en | output | 1 | Left-leg high-side switch enable |
| hi_right_en | output | 1 | Right-leg high-side switch enable |
| lo_left_en | output | 1 | Left-leg low-side switch enable |
| lo_right_en | output | 1 | Right-leg low-side switch enable |
| busy | output | 1 | A symbol is in flight |
| overrun | output | 1 | Sticky: a bit was offered while busy |

## Verification
A corrupted phase or cycle counter shows at the enables in the same cycle. It appears as a drive phase of the wrong length, a missing or doubled dead cycle, or a switch left on in the closing cycle. It is also caught when `busy` drops one cycle early or late. A polarity or width register that changes mid-symbol swaps the driven diagonal or shifts the dead cycle within that symbol. A lost overrun flag is visible on the next cycle after the offending offer, or at any later sample before reset.

// File: rtl/hbseq_pkg.sv
package hbseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_DRIVE  = 3'd1,
        PH_DEAD   = 3'd2,
        PH_RETURN = 3'd3,
        PH_QUIET  = 3'd4
    } phase_t;

    typedef struct packed {
        logic hi_l;
        logic hi_r;
        logic lo_l;
        logic lo_r;
    } gates_t;

    localparam gates_t GATES_OFF = '0;

    // Switch set for one phase; pol=1 drives the right-high/left-low diagonal.
    function automatic gates_t phase_gates(phase_t ph, logic pol);
        gates_t g;
        g = GATES_OFF;
        case (ph)
            PH_DRIVE: begin
                g.hi_r = pol;
                g.lo_l = pol;
                g.hi_l = !pol;
                g.lo_r = !pol;
            end
            PH_DEAD: begin
                g.lo_l = pol;
                g.lo_r = !pol;
            end
            PH_RETURN: begin
                g.lo_l = 1'b1;
                g.lo_r = 1'b1;
            end
            default: g = GATES_OFF;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/hbseq_timer.sv
module hbseq_timer
    import hbseq_pkg::*;
#(
    parameter int SYM_LEN = 16,
    parameter int CNT_W   = $clog2(SYM_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             pol_in,
    input  logic [CNT_W-1:0] width_in,
    output phase_t           phase,
    output logic             pol
);
    localparam int               MAX_W    = SYM_LEN - 3;
    localparam logic [CNT_W-1:0] LAST_RET = CNT_W'(SYM_LEN - 2);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] width_q;
    logic [CNT_W-1:0] width_eff;

    always_comb begin
        if (width_in == '0)
            width_eff = ONE;
        else if (32'(width_in) > MAX_W)
            width_eff = CNT_W'(MAX_W);
        else
            width_eff = width_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            width_q <= ONE;
            pol     <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        phase   <= PH_DRIVE;
                        width_q <= width_eff;
                        pol     <= pol_in;
                    end
                end
                PH_DRIVE: begin
                    cnt <= cnt + ONE;
                    if (cnt == width_q - ONE)
                        phase <= PH_DEAD;
                end
                PH_DEAD: begin
                    cnt   <= cnt + ONE;
                    phase <= PH_RETURN;
                end
                PH_RETURN: begin
                    cnt <= cnt + ONE;
                    if (cnt == LAST_RET)
                        phase <= PH_QUIET;
                end
                default: begin
                    cnt   <= '0;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // R8
    width_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(width_q));

    // R10
    pol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(pol));

    // R4
    one_dead_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        phase == PH_DEAD |=> phase == PH_RETURN);

    // R6
    quiet_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        phase == PH_QUIET |=> phase == PH_IDLE);

endmodule

// File: rtl/hbseq_gate_decode.sv
module hbseq_gate_decode
    import hbseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase,
    input  logic   pol,
    output gates_t gates
);
    always_comb gates = phase_gates(phase, pol);

    // R7
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
        !(gates.hi_l && gates.lo_l) && !(gates.hi_r && gates.lo_r));

    // R7
    left_dead_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gates.lo_l) |-> !$past(gates.hi_l));

    // R7
    right_dead_time_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gates.lo_r) |-> !$past(gates.hi_r));

endmodule

// File: rtl/hbseq_overrun.sv
module hbseq_overrun (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic busy,
    output logic overrun
);
    always_ff @(posedge clk) begin
        if (rst)
            overrun <= 1'b0;
        else if (bit_valid && busy)
            overrun <= 1'b1;
    end

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && busy) |=> overrun);

    // R10
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: rtl/impulse_hbridge_seq.sv
module impulse_hbridge_seq
    import hbseq_pkg::*;
#(
    parameter int SYM_LEN = 16,
    parameter int CNT_W   = $clog2(SYM_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_data,
    input  logic [CNT_W-1:0] pulse_width,
    output logic             hi_left_en,
    output logic             hi_right_en,
    output logic             lo_left_en,
    output logic             lo_right_en,
    output logic             busy,
    output logic             overrun
);
    phase_t phase;
    logic   pol;
    gates_t gates;
    logic   start;

    always_comb begin
        busy  = (phase != PH_IDLE);
        start = bit_valid && !busy;
    end

    hbseq_timer #(.SYM_LEN(SYM_LEN), .CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .pol_in   (bit_data),
        .width_in (pulse_width),
        .phase    (phase),
        .pol      (pol)
    );

    hbseq_gate_decode u_decode (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .pol   (pol),
        .gates (gates)
    );

    hbseq_overrun u_overrun (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .busy      (busy),
        .overrun   (overrun)
    );

    always_comb begin
        hi_left_en  = gates.hi_l;
        hi_right_en = gates.hi_r;
        lo_left_en  = gates.lo_l;
        lo_right_en = gates.lo_r;
    end

    // R6
    idle_all_off_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(hi_left_en || hi_right_en || lo_left_en || lo_right_en));

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !busy) |=> busy);

endmodule

// File: tb/impulse_hbridge_seq_bench.sv
module impulse_hbridge_seq_bench;
    localparam int SYM_LEN = 16;
    localparam int CNT_W   = 4;
    localparam int MAX_W   = SYM_LEN - 3;

    // {polarity, width}
    localparam logic [4:0] VEC [8] = '{5'h12, 5'h02, 5'h11, 5'h0D,
                                       5'h10, 5'h0F, 5'h1E, 5'h07};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             bit_valid = 1'b0;
    logic             bit_data = 1'b0;
    logic [CNT_W-1:0] pulse_width = '0;
    logic hi_left_en, hi_right_en, lo_left_en, lo_right_en, busy, overrun;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    impulse_hbridge_seq #(.SYM_LEN(SYM_LEN), .CNT_W(CNT_W)) u_impulse_hbridge_seq (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
        .pulse_width(pulse_width), .hi_left_en(hi_left_en), .hi_right_en(hi_right_en),
        .lo_left_en(lo_left_en), .lo_right_en(lo_right_en), .busy(busy), .overrun(overrun)
    );

    wire [3:0] g_obs = {hi_left_en, hi_right_en, lo_left_en, lo_right_en};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int eff_w(int w);
        if (w == 0) return 1;
        if (w > MAX_W) return MAX_W;
        return w;
    endfunction

    // order {hi_l, hi_r, lo_l, lo_r}
    function automatic logic [3:0] exp_gates(logic pol, int w, int c);
        if (c < w)             return pol ? 4'b0110 : 4'b1001;
        if (c == w)            return pol ? 4'b0010 : 4'b0001;
        if (c <= SYM_LEN - 2)  return 4'b0011;
        return 4'b0000;
    endfunction

    function automatic string req_of(logic pol, int w, int c);
        if (c == SYM_LEN - 1) return "R6";
        if (!pol)             return "R5";
        if (c < w)            return "R3";
        return "R4";
    endfunction

    // mid_w >= 0 changes pulse_width after acceptance; inject >= 0 offers a bit in that cycle
    task automatic run_symbol(input logic pol, input int win, input int mid_w,
                              input int inject, input bit clamp);
        int w;
        w = eff_w(win);
        @(negedge clk);
        bit_valid   = 1'b1;
        bit_data    = pol;
        pulse_width = CNT_W'(win);
        @(posedge clk);
        @(negedge clk);
        bit_valid = 1'b0;
        if (mid_w >= 0) pulse_width = CNT_W'(mid_w);
        for (int c = 0; c < SYM_LEN; c++) begin
            if (c > 0) begin
                @(posedge clk);
                @(negedge clk);
                bit_valid = 1'b0;
            end
            chk(req_of(pol, w, c), $sformatf("gates cycle %0d", c), 32'(g_obs),
                32'(exp_gates(pol, w, c)));
            chk("R2", $sformatf("busy cycle %0d", c), 32'(busy), 32'd1);
            chk("R7", "same-leg overlap",
                32'((hi_left_en & lo_left_en) | (hi_right_en & lo_right_en)), 32'd0);
            if (clamp && c == w)
                chk("R9", "clamped width dead cycle", 32'(g_obs), 32'(exp_gates(pol, w, c)));
            if (mid_w >= 0 && c == w)
                chk("R8", "width change mid-symbol", 32'(g_obs), 32'(exp_gates(pol, w, c)));
            if (c == inject) begin
                bit_valid = 1'b1;
                bit_data  = ~pol;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R6", "idle gates", 32'(g_obs), 32'd0);
        chk("R2", "busy after symbol", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "gates in reset", 32'(g_obs), 32'd0);
        chk("R1", "busy in reset", 32'(busy), 32'd0);
        chk("R1", "overrun in reset", 32'(overrun), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "gates after reset", 32'(g_obs), 32'd0);

        for (int i = 0; i < 8; i++) begin
            int w;
            w = int'(VEC[i][3:0]);
            run_symbol(VEC[i][4], w, -1, -1, (w == 0 || w > MAX_W));
        end
        chk("R10", "overrun after clean traffic", 32'(overrun), 32'd0);

        // R8: width input changes right after acceptance
        run_symbol(1'b1, 3, 10, -1, 1'b0);
        run_symbol(1'b0, 9, 1, -1, 1'b0);

        // R10: offer during busy is ignored and latched
        run_symbol(1'b1, 4, -1, 1, 1'b0);
        chk("R10", "overrun set", 32'(overrun), 32'd1);
        run_symbol(1'b0, 5, -1, -1, 1'b0);
        chk("R10", "overrun sticky", 32'(overrun), 32'd1);

        // R1: reset mid-symbol
        @(negedge clk);
        bit_valid   = 1'b1;
        bit_data    = 1'b1;
        pulse_width = 4'd6;
        @(posedge clk);
        @(negedge clk);
        bit_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R3", "drive before reset", 32'(g_obs), 32'h6);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "gates after mid reset", 32'(g_obs), 32'd0);
        chk("R1", "busy after mid reset", 32'(busy), 32'd0);
        chk("R1", "overrun cleared", 32'(overrun), 32'd0);
        rst = 1'b0;
        run_symbol(1'b0, 2, -1, -1, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule